// File: doc/BRIEF.md
# Nested Second-Stage Page Table Walker

This block turns a guest-physical address into a host-physical address by reading second-stage translation tables from memory. A request carries the guest-physical address, an access kind (read, store or instruction fetch) and a flag that tells whether the address is the final target of a data access or belongs to a first-stage table fetch. The enable, long-mode and no-execute-enable bits and the table root are sampled together with the request.

With long mode set, the walk descends four levels of 512-entry tables. With long mode clear, a four-entry top table selected by address bits 31:30 leads into the same two lower levels. A walk ends on a 4 KB, 2 MB or 1 GB page and returns the host address, a page-size code and the write and execute rights that survive the walk. It may also end in a fault that reports a syndrome word and the faulting guest address. Entries whose accessed bit is clear are written back with that bit set. One request is handled at a time, and `busy` stays high until the response.

Top module: `nested_walker`

## Requirements
- R1: With `cfg_en` low, an accepted request is answered on the next cycle with `resp_paddr` equal to `req_gpa`, no fault, write and execute granted, size code 0, and no memory request.
- R2: In long mode the walker reads four entries, in order, at table base plus 8 times the index taken from address bits 47:39, 38:30, 29:21 and 20:12. Each next table base is entry bits 51:12. The first base is root bits 51:12. Every memory address is 8-byte aligned.
- R3: With long mode clear, the top table sits at the root with its low 5 bits cleared and is indexed by address bits 31:30. Its entry gives no permissions and never gets an accessed-bit write-back. Its bit 63 is always reserved. The walk then continues at the 2 MB-directory level.
- R4: An entry with bit 0 (present) clear ends the walk with a not-present fault.
- R5: An entry with any of bits 62:52 set, or with bit 63 set while `cfg_nxe` is low, ends the walk with a reserved-bit fault.
- R6: Bit 7 (large page) set is a reserved fault in a long-mode top entry. It selects a 1 GB page in the third-from-leaf entry and a 2 MB page in the directory entry. Otherwise the walk ends on a 4 KB page. Size codes are 0, 1 and 2 for 4 KB, 2 MB and 1 GB.
- R7: For a large page, entry bits 29:13 (1 GB) or 20:13 (2 MB) are reserved. Bit 12 is allowed.
- R8: An entry other than the non-long top entry with bit 5 (accessed) clear is written back to its own address with bit 5 set before the walk goes on.
- R9: User (bit 2) and writable (bit 1) rights are ANDed over all levels. No-execute (bit 63) is ORed over all levels.
- R10: A final result without user right faults as a protection fault. No-execute faults only on a fetch, and read-only faults only on a store. Otherwise they only clear `resp_ex` or `resp_wr`.
- R11: The fault syndrome has bit 0 for protection or reserved faults, bit 1 for a store, bit 2 always set, bit 3 for a reserved fault, bit 4 for a fetch, bit 32 for a final-address request and bit 33 for a table-fetch request. `resp_gpa` carries the request's address.
- R12: A successful result is the leaf entry's page base with the request address bits below the page size. Access kinds are encoded as 0 read, 1 store, 2 fetch.
- R13: `busy` is high from acceptance until the response. Requests are taken only while `busy` is low. A memory request holds its address and direction until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_gpa | input | 52 | Guest-physical address |
| req_acc | input | 2 | Access kind: 0 read, 1 store, 2 fetch |
| req_final | input | 1 | 1 for a final data address, 0 for a first-stage table fetch |
| cfg_en | input | 1 | Second-stage translation enable |
| cfg_long | input | 1 | Four-level walk when set, four-entry top table when clear |
| cfg_nxe | input | 1 | No-execute bit allowed |
| cfg_root | input | 64 | Table root |
| busy | output | 1 | Walk in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 52 | Entry address |
| mem_wdata | output | 64 | Write-back data |
| mem_rvalid | input | 1 | Read data valid (always accepted) |
| mem_rdata | input | 64 | Read data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_paddr | output | 52 | Host-physical address |
| resp_size | output | 2 | Page size code |
| resp_wr | output | 1 | Write allowed |
| resp_ex | output | 1 | Execute allowed |
| resp_info | output | 64 | Fault syndrome |
| resp_gpa | output | 52 | Guest address of the request |

## Verification
The embedded properties check on every cycle that the bypass answers a cycle later with the input address and without touching memory. They also check that memory requests are aligned and held stable until accepted, that a write-back only follows a read response, and that every syndrome carries the user flag and exactly one of the final/table flags, with the reserved flag implying the present flag. They also check that a successful result keeps the request's low 12 bits. Which fault a given table layout produces, the exact read and write-back counts, the page-size selection, the reserved low bits of large pages and the permission merging across levels can only be shown by the bench's table scenarios.

// File: rtl/nested_walker.sv
module nested_walker #(
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [PA_W-1:0] req_gpa,
  input  logic [1:0]      req_acc,
  input  logic            req_final,
  input  logic            cfg_en,
  input  logic            cfg_long,
  input  logic            cfg_nxe,
  input  logic [63:0]     cfg_root,
  output logic            busy,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [63:0]     mem_wdata,
  input  logic            mem_rvalid,
  input  logic [63:0]     mem_rdata,
  output logic            resp_valid,
  output logic            resp_fault,
  output logic [PA_W-1:0] resp_paddr,
  output logic [1:0]      resp_size,
  output logic            resp_wr,
  output logic            resp_ex,
  output logic [63:0]     resp_info,
  output logic [PA_W-1:0] resp_gpa
);
  localparam int PG = 12;
  localparam int IW = 9;
  localparam logic [1:0] ACC_ST = 2'd1;
  localparam logic [1:0] ACC_IF = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WB, S_STEP} st_t;

  st_t             st;
  logic [PA_W-1:0] gpa_q, base, ent_addr;
  logic [1:0]      acc_q, lvl, sz_q;
  logic            fin_q, nxe_q, top_pae, leaf_q, u_acc, w_acc, nx_acc;
  logic [63:0]     ent;

  wire unused_root = ^{cfg_root[63:PA_W], cfg_root[4:0]};

  wire [IW-1:0]   idx     = gpa_q[PG + IW*lvl +: IW];
  wire [PA_W-1:0] rd_addr = top_pae ? base + PA_W'({gpa_q[31:30], 3'b000})
                                    : base + PA_W'({idx, 3'b000});

  wire [63:0] e      = mem_rdata;
  wire        ps     = e[7];
  wire        hi_rsv = |e[62:PA_W];
  wire        nx_rsv = e[63] & (top_pae | !nxe_q);
  wire        ps_bad = ps & !top_pae & (lvl == 2'd3);
  wire        lg_rsv = ps & !top_pae & (((lvl == 2'd2) & |e[29:13]) | ((lvl == 2'd1) & |e[20:13]));
  wire        rsv    = hi_rsv | nx_rsv | ps_bad | lg_rsv;
  wire        leaf   = !top_pae & ((lvl == 2'd0) | (ps & ((lvl == 2'd1) | (lvl == 2'd2))));

  function automatic logic [63:0] syndrome(input logic prot, input logic rsvd);
    syndrome = 64'h4;
    syndrome[0]  = prot | rsvd;
    syndrome[3]  = rsvd;
    syndrome[1]  = (acc_q == ACC_ST);
    syndrome[4]  = (acc_q == ACC_IF);
    syndrome[32] = fin_q;
    syndrome[33] = !fin_q;
  endfunction

  logic [PA_W-1:0] leaf_pa;
  always_comb begin
    case (sz_q)
      2'd1:    leaf_pa = {ent[PA_W-1:21], gpa_q[20:0]};
      2'd2:    leaf_pa = {ent[PA_W-1:30], gpa_q[29:0]};
      default: leaf_pa = {ent[PA_W-1:12], gpa_q[11:0]};
    endcase
  end

  wire prot_fail = !u_acc | (nx_acc & (acc_q == ACC_IF)) | (!w_acc & (acc_q == ACC_ST));

  assign busy      = (st != S_IDLE);
  assign mem_valid = (st == S_RD) | (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? ent_addr : rd_addr;
  assign mem_wdata = ent | 64'h20;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; resp_valid <= 1'b0; resp_fault <= 1'b0; resp_paddr <= '0;
      resp_size <= 2'd0; resp_wr <= 1'b0; resp_ex <= 1'b0; resp_info <= '0; resp_gpa <= '0;
      gpa_q <= '0; base <= '0; ent_addr <= '0; acc_q <= '0; lvl <= '0; sz_q <= '0;
      fin_q <= 1'b0; nxe_q <= 1'b0; top_pae <= 1'b0; leaf_q <= 1'b0;
      u_acc <= 1'b0; w_acc <= 1'b0; nx_acc <= 1'b0; ent <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          gpa_q <= req_gpa; acc_q <= req_acc; fin_q <= req_final; nxe_q <= cfg_nxe;
          u_acc <= 1'b1; w_acc <= 1'b1; nx_acc <= 1'b0;
          if (!cfg_en) begin
            resp_valid <= 1'b1; resp_fault <= 1'b0; resp_paddr <= req_gpa; resp_size <= 2'd0;
            resp_wr <= 1'b1; resp_ex <= 1'b1; resp_info <= '0; resp_gpa <= req_gpa;
          end else begin
            st      <= S_RD;
            top_pae <= !cfg_long;
            lvl     <= cfg_long ? 2'd3 : 2'd2;
            base    <= cfg_long ? {cfg_root[PA_W-1:PG], {PG{1'b0}}} : {cfg_root[PA_W-1:5], 5'b0};
          end
        end
        S_RD: if (mem_ready) begin
          ent_addr <= rd_addr;
          st       <= S_WAIT;
        end
        S_WAIT: if (mem_rvalid) begin
          ent <= e;
          if (!e[0] || rsv) begin
            resp_valid <= 1'b1; resp_fault <= 1'b1; resp_paddr <= '0; resp_size <= 2'd0;
            resp_wr <= 1'b0; resp_ex <= 1'b0; resp_gpa <= gpa_q;
            resp_info <= syndrome(1'b0, e[0]);
            st <= S_IDLE;
          end else begin
            if (!top_pae) begin
              u_acc <= u_acc & e[2]; w_acc <= w_acc & e[1]; nx_acc <= nx_acc | e[63];
            end
            leaf_q <= leaf;
            sz_q   <= (ps && lvl == 2'd2) ? 2'd2 : (ps && lvl == 2'd1) ? 2'd1 : 2'd0;
            st     <= (!top_pae && !e[5]) ? S_WB : S_STEP;
          end
        end
        S_WB: if (mem_ready) st <= S_STEP;
        S_STEP: begin
          if (leaf_q) begin
            resp_valid <= 1'b1; resp_fault <= prot_fail; resp_gpa <= gpa_q;
            resp_paddr <= prot_fail ? '0 : leaf_pa;
            resp_size  <= prot_fail ? 2'd0 : sz_q;
            resp_wr    <= !prot_fail & w_acc;
            resp_ex    <= !prot_fail & !nx_acc;
            resp_info  <= prot_fail ? syndrome(1'b1, 1'b0) : 64'h0;
            st <= S_IDLE;
          end else begin
            base    <= {ent[PA_W-1:PG], {PG{1'b0}}};
            lvl     <= top_pae ? 2'd1 : lvl - 2'd1;
            top_pae <= 1'b0;
            st      <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !cfg_en) |=> (resp_valid && !resp_fault && resp_paddr == $past(req_gpa)));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);
  assert_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[2:0] == 3'b000));
  assert_wb_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !$past(mem_valid && mem_we)) |-> $past(mem_rvalid));
  assert_syndrome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_info[2] && (resp_info[32] ^ resp_info[33])
                                    && (!resp_info[3] || resp_info[0])));
  assert_offset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> (resp_paddr[11:0] == resp_gpa[11:0]));
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/nested_walker_tb.sv
module nested_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [51:0] req_gpa = '0;
  logic [1:0]  req_acc = '0;
  logic        req_final = 1'b1, cfg_en = 1'b0, cfg_long = 1'b1, cfg_nxe = 1'b1;
  logic [63:0] cfg_root = '0;
  logic        busy, mem_valid, mem_we, mem_ready, mem_rvalid;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        resp_valid, resp_fault, resp_wr, resp_ex;
  logic [51:0] resp_paddr, resp_gpa;
  logic [1:0]  resp_size;
  logic [63:0] resp_info;

  always #5 clk = ~clk;

  nested_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_gpa(req_gpa), .req_acc(req_acc),
    .req_final(req_final), .cfg_en(cfg_en), .cfg_long(cfg_long), .cfg_nxe(cfg_nxe),
    .cfg_root(cfg_root), .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .resp_size(resp_size), .resp_wr(resp_wr), .resp_ex(resp_ex),
    .resp_info(resp_info), .resp_gpa(resp_gpa));

  logic [63:0] mem [logic [51:0]];
  int rd_cnt = 0, wr_cnt = 0, cyc = 0;
  initial begin mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0; end
  always @(posedge clk) begin
    cyc = cyc + 1;
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin mem[mem_addr] = mem_wdata; wr_cnt = wr_cnt + 1; end
      else begin
        mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
        mem_rvalid <= 1'b1;
        rd_cnt = rd_cnt + 1;
      end
    end
    mem_ready <= (cyc % 3) != 1;
  end

  int checks = 0, errors = 0;
  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  logic busy_seen;
  int   rd_d, wr_d;
  task automatic run(input logic [51:0] g, input logic [1:0] a, input logic f,
                     input logic en, input logic lng, input logic nx, input logic [63:0] root);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_gpa = g; req_acc = a; req_final = f;
    cfg_en = en; cfg_long = lng; cfg_nxe = nx; cfg_root = root;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = busy;
    while (!resp_valid) @(negedge clk);
    rd_d = rd_cnt - r0; wr_d = wr_cnt - w0;
  endtask

  typedef struct packed {
    logic [51:0] gpa; logic [1:0] acc; logic fin; logic nxe; logic lng;
    logic flt; logic [63:0] info; logic [51:0] pa; logic [1:0] sz; logic w; logic x;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{52'h0000000000ABC, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0,           52'h123ABC,   2'd0, 1'b1, 1'b1},
    '{52'h0000000001010, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1_0000_0007, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000000001010, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0,           52'h456010,   2'd0, 1'b0, 1'b1},
    '{52'h0000000205123, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0,           52'h605123,   2'd1, 1'b1, 1'b1},
    '{52'h0000000400321, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h2_0000_0007, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000000400321, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0,           52'h800321,   2'd1, 1'b0, 1'b1},
    '{52'h0000000600000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1_0000_0004, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000000800044, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1_0000_0015, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000000800044, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0,           52'hA00044,   2'd1, 1'b1, 1'b0},
    '{52'h0000000800044, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 64'h1_0000_000D, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000000A00000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1_0000_0005, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000000C00000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1_0000_000D, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000052345678, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0,           52'hD2345678, 2'd2, 1'b1, 1'b1},
    '{52'h0000080000000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1_0000_000D, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h00000C0001000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0,           52'h40001000, 2'd2, 1'b1, 1'b1},
    '{52'h0008000000000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1_0000_000D, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000040000777, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0,           52'h123777,   2'd0, 1'b1, 1'b1},
    '{52'h0000080000000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 64'h1_0000_000D, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000000000000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 64'h1_0000_0004, 52'h0,        2'd0, 1'b0, 1'b0},
    '{52'h0000040200010, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0,           52'h600010,   2'd1, 1'b1, 1'b1}
  };

  function automatic string tag_of(input int i);
    case (i)
      0:              return "R2";
      1, 5, 7:        return "R10";
      2, 8, 10:       return "R9";
      3, 12, 15:      return "R6";
      4:              return "R11";
      6, 18:          return "R4";
      9, 11:          return "R5";
      13, 14:         return "R7";
      default:        return "R3";
    endcase
  endfunction

  initial begin
    mem[52'h1000] = 64'h2007;
    mem[52'h1008] = 64'h30A7;
    mem[52'h2000] = 64'h3027;
    mem[52'h2008] = 64'hC00000A7;
    mem[52'h2010] = 64'h800020A7;
    mem[52'h2018] = 64'h400010A7;
    mem[52'h3000] = 64'h4027;
    mem[52'h3008] = 64'h006000A7;
    mem[52'h3010] = 64'h008000A5;
    mem[52'h3020] = 64'h8000_0000_00A0_00A7;
    mem[52'h3028] = 64'h5023;
    mem[52'h3030] = 64'h0010_0000_0000_3027;
    mem[52'h4000] = 64'h00123027;
    mem[52'h4008] = 64'h00456025;
    mem[52'h5000] = 64'h00789027;
    mem[52'h6008] = 64'h3001;
    mem[52'h6010] = 64'h8000_0000_0000_3001;

    repeat (3) @(negedge clk);
    chk(!busy && !resp_valid && !mem_valid, "R13 reset idle", {61'd0, busy, resp_valid, mem_valid}, 64'h0);
    rst_n = 1'b1;

    run(52'hABCDEF12345, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 64'h1000);
    chk(!resp_fault && resp_paddr == 52'hABCDEF12345, "R1 bypass address", {12'd0, resp_paddr}, 64'hABCDEF12345);
    chk(resp_wr && resp_ex && resp_size == 2'd0, "R1 bypass rights", {60'd0, resp_size, resp_wr, resp_ex}, 64'h3);
    chk(rd_d == 0 && wr_d == 0, "R1 no memory traffic", 64'(rd_d + wr_d), 64'h0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i].gpa, VEC[i].acc, VEC[i].fin, 1'b1, VEC[i].lng, VEC[i].nxe,
          VEC[i].lng ? 64'h1000 : 64'h601F);
      chk(resp_fault == VEC[i].flt, tag_of(i), {63'd0, resp_fault}, {63'd0, VEC[i].flt});
      if (VEC[i].flt) begin
        chk(resp_info == VEC[i].info, "R11 syndrome", resp_info, VEC[i].info);
        chk(resp_gpa == VEC[i].gpa, "R11 fault address", {12'd0, resp_gpa}, {12'd0, VEC[i].gpa});
      end else begin
        chk(resp_paddr == VEC[i].pa && resp_size == VEC[i].sz, "R12 result",
            {10'd0, resp_size, resp_paddr}, {10'd0, VEC[i].sz, VEC[i].pa});
        chk(resp_wr == VEC[i].w && resp_ex == VEC[i].x, "R9 rights",
            {62'd0, resp_wr, resp_ex}, {62'd0, VEC[i].w, VEC[i].x});
      end
      if (i == 0) begin
        chk(busy_seen, "R13 busy during walk", {63'd0, busy_seen}, 64'h1);
        chk(rd_d == 4, "R2 four reads", 64'(rd_d), 64'd4);
        chk(wr_d == 1 && mem[52'h1000] == 64'h2027, "R8 accessed write-back", mem[52'h1000], 64'h2027);
      end
      if (i == 16) begin
        chk(rd_d == 3, "R3 three reads", 64'(rd_d), 64'd3);
        chk(wr_d == 0 && mem[52'h6008] == 64'h3001, "R3 top entry untouched", mem[52'h6008], 64'h3001);
      end
      if (i == 12) chk(rd_d == 2, "R6 two reads for 1 GB page", 64'(rd_d), 64'd2);
    end

    run(52'h0000000000ABC, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1000);
    chk(wr_d == 0, "R8 no write when accessed set", 64'(wr_d), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R13 watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule